// File: doc/BRIEF.md
# CAN Error Diagnostic Status Logger

This block sits beside a CAN FD protocol engine and gathers the engine's error events into one 32-bit diagnostic status word. Once per bit time the engine presents the level it drove, the level it sampled, whether the bit lies in the data phase, and whether the bit is in a stuffed part of the frame. From these the block finds bit errors and stuff errors on its own. CRC, form, acknowledge, length-mismatch, error-state-indicator and bus-off events arrive as one-cycle strobes from the engine.

Each event sets a sticky flag in the upper half of the word. Errors that can occur in either part of a frame have two flags, one for the data phase and one for the rest of the frame. The lower half is a saturating count of frames that completed without error. While the node recovers from bus-off, the block counts recessive bits and marks each completed run of eleven, so software can see that recovery is progressing. Software reads the word and may overwrite it; writing zero clears it.

Top module: `can_diag_logger`

## Requirements
- R1: After reset `status` reads 0x00000000.
- R2: On a `bit_en` cycle with `tx_active`=1, `tx_lvl`=1 and `rx_lvl`=0 (recessive driven, dominant seen), bit 25 is set if `data_phase`=1 and bit 17 otherwise, visible one clock later.
- R3: On a `bit_en` cycle with `tx_active`=1, `tx_lvl`=0 and `rx_lvl`=1 (dominant driven, recessive seen), bit 24 is set if `data_phase`=1 and bit 16 otherwise, visible one clock later.
- R4: Inside `stuff_region`, a sampled bit equal to the five before it (the run restarting at `sof` and at every `stuff_bit`) sets bit 28 in the data phase and bit 20 otherwise; runs outside `stuff_region` are never flagged.
- R5: `crc_err` sets bit 29 with `data_phase`=1 and bit 21 otherwise; `form_err` sets bit 27 or bit 19 the same way.
- R6: `ack_err` sets bit 18, `busoff_enter` sets bit 23, `esi_rx` sets bit 30 and `dlc_mm` sets bit 31.
- R7: While `busoff_rec`=1, every eleventh consecutive recessive `bit_en` sample sets bit 16 and starts a new run; a dominant sample or `busoff_rec`=0 restarts the run.
- R8: Bits 15:0 count `frame_ok` strobes, holding at 0xFFFF instead of wrapping.
- R9: `sw_we` loads `sw_wdata` into the word one clock later, except that bits 26 and 22 always read 0.
- R10: An event in the same cycle as `sw_we` still sets its flag, and a `frame_ok` in that cycle counts on top of the written value.
- R11: Without `sw_we` a set flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle strobe per bit time; qualifies the level inputs |
| tx_active | input | 1 | Node is transmitting this bit |
| tx_lvl | input | 1 | Level driven (1 = recessive) |
| rx_lvl | input | 1 | Level sampled on the bus (1 = recessive) |
| data_phase | input | 1 | Current bit or event belongs to the data phase |
| stuff_region | input | 1 | Current bit lies in a stuffed part of the frame |
| stuff_bit | input | 1 | Current bit is a stuff bit |
| sof | input | 1 | Current bit is start of frame |
| frame_ok | input | 1 | Frame completed with no error |
| crc_err | input | 1 | CRC mismatch strobe |
| form_err | input | 1 | Fixed-format field error strobe |
| ack_err | input | 1 | Transmitted frame not acknowledged |
| dlc_mm | input | 1 | Length code exceeds the buffer element payload size |
| esi_rx | input | 1 | Received FD frame carries the error-state indicator |
| busoff_enter | input | 1 | Node entered bus-off |
| busoff_rec | input | 1 | Bus-off recovery in progress |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| status | output | 32 | Diagnostic status word |

## Verification
The properties assume the engine never asserts `tx_active` while `busoff_rec` is high, and that `sof` and `stuff_bit` only accompany a `bit_en` inside `stuff_region`. The stimulus respects this by driving recovery bits only with the transmitter idle and by raising `sof` and `stuff_bit` only on in-region bit times. Event strobes are single-cycle and may coincide with each other and with software writes, which the bench exercises on purpose.

// File: rtl/can_diag_pkg.sv
package can_diag_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 16;
  localparam int FLG_W  = WORD_W - CNT_W;

  // flag positions inside the status word
  localparam int B_DLC   = 31;
  localparam int B_ESI   = 30;
  localparam int B_DCRC  = 29;
  localparam int B_DSTF  = 28;
  localparam int B_DFRM  = 27;
  localparam int B_DREC  = 25;
  localparam int B_DDOM  = 24;
  localparam int B_BOFF  = 23;
  localparam int B_NCRC  = 21;
  localparam int B_NSTF  = 20;
  localparam int B_NFRM  = 19;
  localparam int B_ACK   = 18;
  localparam int B_NREC  = 17;
  localparam int B_NDOM  = 16;

  localparam logic [WORD_W-1:0] KEEP_MASK = ~((32'd1 << 26) | (32'd1 << 22));

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == {CNT_W{1'b1}}) ? v : v + 1'b1;
  endfunction

  // one-hot mask for an event that lands in a data or non-data flag
  function automatic logic [WORD_W-1:0] seg_mask(input logic ev, input logic dp,
                                                 input int dpos, input int npos);
    logic [WORD_W-1:0] m;
    m = '0;
    if (ev) m[dp ? dpos : npos] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/can_bit_mon.sv
module can_bit_mon #(
  parameter int RUN_MAX = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic tx_active,
  input  logic tx_lvl,
  input  logic rx_lvl,
  input  logic stuff_region,
  input  logic stuff_bit,
  input  logic sof,
  output logic err_rec,
  output logic err_dom,
  output logic err_stuff
);
  localparam int RW = $clog2(RUN_MAX + 1);

  logic [RW-1:0] run_q;
  logic          last_q;
  logic          restart;

  assign err_rec = bit_en & tx_active & tx_lvl & ~rx_lvl;
  assign err_dom = bit_en & tx_active & ~tx_lvl & rx_lvl;

  assign restart   = sof | stuff_bit | (run_q == '0) | (rx_lvl != last_q);
  assign err_stuff = bit_en & stuff_region & ~restart &
                     (run_q >= RW'(RUN_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      last_q <= 1'b1;
    end else if (bit_en) begin
      if (!stuff_region) begin
        run_q <= '0;
      end else begin
        last_q <= rx_lvl;
        if (restart)
          run_q <= RW'(1);
        else if (run_q < RW'(RUN_MAX))
          run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_busoff_watch.sv
module can_busoff_watch #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_lvl,
  input  logic busoff_rec,
  output logic rec_pulse
);
  localparam int CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] cnt_q;

  assign rec_pulse = busoff_rec & bit_en & rx_lvl & (cnt_q == CW'(RUN_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!busoff_rec)
      cnt_q <= '0;
    else if (bit_en) begin
      if (!rx_lvl || rec_pulse)
        cnt_q <= '0;
      else
        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/can_diag_reg.sv
module can_diag_reg
  import can_diag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] set_vec,
  input  logic              frame_ok,
  input  logic              sw_we,
  input  logic [WORD_W-1:0] sw_wdata,
  output logic [WORD_W-1:0] word_q
);
  logic [WORD_W-1:0] base;
  logic [FLG_W-1:0]  flg_n;
  logic [CNT_W-1:0]  cnt_n;

  always_comb begin
    base  = sw_we ? sw_wdata : word_q;
    flg_n = (base[WORD_W-1:CNT_W] | set_vec[WORD_W-1:CNT_W]) & KEEP_MASK[WORD_W-1:CNT_W];
    cnt_n = frame_ok ? sat_inc(base[CNT_W-1:0]) : base[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= {flg_n, cnt_n};
  end
endmodule

// File: rtl/can_diag_logger.sv
module can_diag_logger
  import can_diag_pkg::*;
#(
  parameter int STUFF_RUN = 5,
  parameter int IDLE_RUN  = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_en,
  input  logic        tx_active,
  input  logic        tx_lvl,
  input  logic        rx_lvl,
  input  logic        data_phase,
  input  logic        stuff_region,
  input  logic        stuff_bit,
  input  logic        sof,
  input  logic        frame_ok,
  input  logic        crc_err,
  input  logic        form_err,
  input  logic        ack_err,
  input  logic        dlc_mm,
  input  logic        esi_rx,
  input  logic        busoff_enter,
  input  logic        busoff_rec,
  input  logic        sw_we,
  input  logic [31:0] sw_wdata,
  output logic [31:0] status
);
  logic err_rec_w, err_dom_w, err_stuff_w, rec_pulse_w;
  logic [WORD_W-1:0] set_w;

  can_bit_mon #(.RUN_MAX(STUFF_RUN)) u_bitmon (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_active(tx_active),
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .stuff_region(stuff_region),
    .stuff_bit(stuff_bit), .sof(sof),
    .err_rec(err_rec_w), .err_dom(err_dom_w), .err_stuff(err_stuff_w)
  );

  can_busoff_watch #(.RUN_LEN(IDLE_RUN)) u_bowatch (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_lvl(rx_lvl),
    .busoff_rec(busoff_rec), .rec_pulse(rec_pulse_w)
  );

  always_comb begin
    set_w = seg_mask(err_rec_w,   data_phase, B_DREC, B_NREC)
          | seg_mask(err_dom_w,   data_phase, B_DDOM, B_NDOM)
          | seg_mask(err_stuff_w, data_phase, B_DSTF, B_NSTF)
          | seg_mask(crc_err,     data_phase, B_DCRC, B_NCRC)
          | seg_mask(form_err,    data_phase, B_DFRM, B_NFRM);
    if (rec_pulse_w)  set_w[B_NDOM] = 1'b1;
    if (ack_err)      set_w[B_ACK]  = 1'b1;
    if (busoff_enter) set_w[B_BOFF] = 1'b1;
    if (esi_rx)       set_w[B_ESI]  = 1'b1;
    if (dlc_mm)       set_w[B_DLC]  = 1'b1;
  end

  can_diag_reg u_reg (
    .clk(clk), .rst_n(rst_n), .set_vec(set_w), .frame_ok(frame_ok),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .word_q(status)
  );
endmodule

// File: rtl/can_diag_logger_chk.sv
module can_diag_logger_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        data_phase,
  input logic        busoff_rec,
  input logic        busoff_enter,
  input logic        sw_we,
  input logic        err_rec,
  input logic        err_stuff,
  input logic        rec_pulse,
  input logic [31:0] status
);
  // R2: a non-data recessive-expected error shows up in bit 17
  p_rec_nd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_rec && !data_phase |=> status[17]);
  // R4: a detected stuff error lands in one of its two flags
  p_stuff_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_stuff |=> (status[28] || status[20]));
  // R7: recovery marks only happen during recovery and reach bit 16
  p_rec_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_pulse |-> busoff_rec);
  p_rec_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_pulse |=> status[16]);
  // R8: counter moves by at most one and holds at its ceiling
  p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we |=> (status[15:0] == $past(status[15:0]) ||
                status[15:0] == $past(status[15:0]) + 16'd1));
  p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we && status[15:0] == 16'hFFFF |=> status[15:0] == 16'hFFFF);
  // R9: reserved positions never read 1
  p_unused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !status[26] && !status[22]);
  // R10: hardware set beats a same-cycle write
  p_hw_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we && busoff_enter |=> status[23]);
  // R11: flags are sticky without a write
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we |=> ((status[31:16] & $past(status[31:16])) == $past(status[31:16])));
endmodule

bind can_diag_logger can_diag_logger_chk chk_i (
  .clk(clk), .rst_n(rst_n), .data_phase(data_phase), .busoff_rec(busoff_rec),
  .busoff_enter(busoff_enter), .sw_we(sw_we), .err_rec(err_rec_w),
  .err_stuff(err_stuff_w), .rec_pulse(rec_pulse_w), .status(status)
);

// File: tb/can_diag_logger_tb.sv
module can_diag_logger_tb_top;
  logic clk = 0, rst_n = 0;
  logic bit_en = 0, tx_active = 0, tx_lvl = 1, rx_lvl = 1, data_phase = 0;
  logic stuff_region = 0, stuff_bit = 0, sof = 0, frame_ok = 0;
  logic crc_err = 0, form_err = 0, ack_err = 0, dlc_mm = 0, esi_rx = 0;
  logic busoff_enter = 0, busoff_rec = 0, sw_we = 0;
  logic [31:0] sw_wdata = 0;
  logic [31:0] status;

  int checks = 0, fails = 0;
  string tag = "R1";
  logic [31:0] m_word = 0;
  int m_run = 0, m_prev = 1, m_idle = 0;
  logic done = 0;

  always #5 clk = ~clk;

  can_diag_logger dut_i (.*);

  task automatic check(input string t, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: status=%08h expected %08h", t, got, exp);
    end
  endtask

  // reference: next word from current inputs and model state
  task automatic model_step();
    logic [31:0] w;
    int c;
    w = sw_we ? (sw_wdata & 32'hFBBF_FFFF) : m_word;
    c = w[15:0];
    if (frame_ok && c != 65535) c = c + 1;
    if (bit_en && tx_active && tx_lvl && !rx_lvl) w[data_phase ? 25 : 17] = 1;
    if (bit_en && tx_active && !tx_lvl && rx_lvl) w[data_phase ? 24 : 16] = 1;
    if (bit_en) begin
      if (stuff_region) begin
        if (sof || stuff_bit || m_run == 0 || int'(rx_lvl) != m_prev) m_run = 1;
        else begin
          m_run = m_run + 1;
          if (m_run >= 6) w[data_phase ? 28 : 20] = 1;
        end
        m_prev = rx_lvl;
      end else m_run = 0;
    end
    if (!busoff_rec) m_idle = 0;
    else if (bit_en) begin
      if (rx_lvl) begin
        m_idle = m_idle + 1;
        if (m_idle == 11) begin w[16] = 1; m_idle = 0; end
      end else m_idle = 0;
    end
    if (crc_err)  w[data_phase ? 29 : 21] = 1;
    if (form_err) w[data_phase ? 27 : 19] = 1;
    if (ack_err) w[18] = 1;
    if (busoff_enter) w[23] = 1;
    if (esi_rx) w[30] = 1;
    if (dlc_mm) w[31] = 1;
    w[15:0] = c[15:0];
    m_word = w;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk); #1;
    check(tag, status, m_word);
    bit_en = 0; sof = 0; stuff_bit = 0; frame_ok = 0; crc_err = 0; form_err = 0;
    ack_err = 0; dlc_mm = 0; esi_rx = 0; busoff_enter = 0; sw_we = 0;
  endtask

  task automatic send(input logic t, input logic r);
    bit_en = 1; tx_lvl = t; rx_lvl = r; cyc();
  endtask

  task automatic wr(input logic [31:0] v);
    sw_we = 1; sw_wdata = v; cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    tag = "R1"; check(tag, status, 32'h0);
    rst_n = 1;
    cyc();

    // R2 / R3 bit errors in both segments
    tag = "R2"; tx_active = 1; data_phase = 0; send(1, 0);
    check("R2 nd", status & 32'h0200_0000 | status & 32'h0002_0000, 32'h0002_0000);
    data_phase = 1; send(1, 0);
    check("R2 d", status[25], 1);
    tag = "R3"; wr(0); data_phase = 0; send(0, 1);
    check("R3 nd", status, 32'h0001_0000);
    data_phase = 1; send(0, 1); send(1, 1); send(0, 0);
    check("R3 d", status, 32'h0101_0000);
    tx_active = 0;

    // R4 stuff handling
    tag = "R4"; wr(0); data_phase = 0; stuff_region = 1;
    sof = 1; send(1, 0);
    repeat (4) send(1, 0);
    check("R4 five ok", status, 32'h0);
    send(1, 0);
    check("R4 sixth nd", status, 32'h0010_0000);
    wr(0); data_phase = 1;
    sof = 1; send(1, 1); repeat (4) send(1, 1);
    stuff_bit = 1; send(1, 1);
    repeat (4) send(1, 1);
    check("R4 stuff restart", status, 32'h0);
    send(1, 1);
    check("R4 sixth d", status, 32'h1000_0000);
    wr(0); stuff_region = 0; repeat (9) send(1, 0);
    check("R4 outside", status, 32'h0);
    data_phase = 0;

    // R5 / R6 strobes
    tag = "R5"; crc_err = 1; cyc(); data_phase = 1; crc_err = 1; form_err = 1; cyc();
    data_phase = 0; form_err = 1; cyc();
    check("R5", status, 32'h2828_0000);
    tag = "R6"; wr(0); ack_err = 1; busoff_enter = 1; cyc(); esi_rx = 1; dlc_mm = 1; cyc();
    check("R6", status, 32'hC084_0000);
    tag = "R11"; repeat (3) cyc();
    check("R11", status, 32'hC084_0000);

    // R8 counter
    tag = "R8"; wr(0); repeat (3) begin frame_ok = 1; cyc(); end
    check("R8 count", status, 32'd3);
    wr(32'h0000_FFFE); frame_ok = 1; cyc(); frame_ok = 1; cyc();
    check("R8 sat", status, 32'h0000_FFFF);

    // R9 write and reserved bits
    tag = "R9"; wr(32'hFFFF_1234);
    check("R9", status, 32'hFBBF_1234);

    // R10 same-cycle write and events
    tag = "R10"; sw_we = 1; sw_wdata = 32'h0000_0010; busoff_enter = 1; frame_ok = 1; cyc();
    check("R10", status, 32'h0080_0011);
    sw_we = 1; sw_wdata = 32'h0000_FFFF; frame_ok = 1; cyc();
    check("R10 sat", status, 32'h0000_FFFF);

    // R7 bus-off recovery
    tag = "R7"; wr(0); busoff_rec = 1;
    repeat (10) send(1, 1);
    check("R7 ten", status, 32'h0);
    send(1, 0); repeat (10) send(1, 1);
    check("R7 restart", status, 32'h0);
    send(1, 1);
    check("R7 eleventh", status, 32'h0001_0000);
    wr(0); repeat (10) send(1, 1);
    busoff_rec = 0; cyc(); busoff_rec = 1;
    send(1, 1);
    check("R7 exit clears run", status, 32'h0);
    repeat (10) send(1, 1);
    check("R7 second run", status, 32'h0001_0000);
    busoff_rec = 0; cyc();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule